// File: doc/BRIEF.md
# Age-Priority Multi-Issue Queue

This block buffers renamed instructions until every source operand they need has been produced. It then sends them to execution, up to four per cycle, always choosing the oldest ready instructions first. A front end writes instructions in program order through a small set of dispatch lanes. Each lane carries an opaque payload, one tag per source operand and a flag per source that says whether the operand is already available. Producers broadcast destination tags on the wakeup lanes. A waiting source whose tag matches a broadcast becomes available.

An instruction that issues does not leave the queue at once. It stays held for a short replay window. If a load in flight turns out to miss, the pipeline raises replay together with the load's destination tag. Every held instruction then returns to the waiting state, and any source of theirs that named that tag becomes unavailable again. These instructions issue a second time once the tag is broadcast again. A squash input drops the whole queue content after a mis-speculation.

Top module: `age_issue_queue`

## Requirements
- R1: After reset the queue is empty, no issue lane is valid and full_o is low.
- R2: An entry is eligible only when all of its sources are available. A wakeup matching its last unavailable source in cycle N makes it issue in cycle N+1. An entry dispatched with all sources available issues in the cycle after dispatch.
- R3: A wakeup broadcast in the same cycle as the dispatch of an entry marks the matching sources of that entry as available.
- R4: Each cycle, min(ISSUE_W, number of eligible entries) entries issue on lanes 0 upwards with no gaps. Lane 0 carries the oldest. Age follows dispatch order, a lower dispatch lane is older within one cycle, and the slot position has no effect.
- R5: An issued entry keeps its slot for REPLAY_WIN cycles after its issue cycle, and the slot becomes free at the following clock edge.
- R6: replay_i returns every held entry to waiting. Sources equal to replay_tag_i become unavailable. Other sources stay available, so an entry with no matching source issues again in the next cycle.
- R7: replay_i has no effect on entries whose replay window has closed.
- R8: full_o is high exactly when fewer than DISP_W slots are free. While full_o is high, all dispatch lanes are ignored.
- R9: squash_i frees every entry, waiting or held, at the next edge. Dispatches in the squash cycle are dropped, and a later replay does not bring squashed entries back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| disp_valid_i | input | DISP_W | Dispatch lane valid, lane 0 oldest |
| disp_src_tag_i | input | DISP_W*NSRC*TAG_W | Source tags; lane l source s at bits ((l*NSRC)+s)*TAG_W |
| disp_src_rdy_i | input | DISP_W*NSRC | Source already available; lane l source s at bit l*NSRC+s |
| disp_payload_i | input | DISP_W*PAY_W | Opaque instruction payload per lane |
| full_o | output | 1 | Fewer than DISP_W free slots |
| wake_valid_i | input | WAKE_W | Wakeup broadcast valid per lane |
| wake_tag_i | input | WAKE_W*TAG_W | Destination tag broadcast per lane |
| issue_valid_o | output | ISSUE_W | Issue lane valid |
| issue_payload_o | output | ISSUE_W*PAY_W | Payload of the issued entry per lane |
| squash_i | input | 1 | Drop all entries |
| replay_i | input | 1 | Return held entries to waiting |
| replay_tag_i | input | TAG_W | Tag of the load whose consumers must wait again |

## Verification
A corrupted age relation shows up as payloads that appear on the wrong issue lane, or that leave in the wrong cycle, when more than four entries are eligible at once. This is visible in the first such cycle. A readiness bit that is stuck or lost shows up as an issue one cycle early or never. A replay window count that is off by one shows up at full_o, which falls one cycle early or late after a full queue drains. It also shows up as a replay near the window edge that fails to bring an entry back, or that brings back an entry already released. The scoreboard expects every payload in one exact cycle and on one exact lane, so each of these faults fails within the cycle it occurs.

// File: rtl/iq_pkg.sv
package iq_pkg;
  typedef enum logic [1:0] {
    SLOT_FREE = 2'd0,
    SLOT_WAIT = 2'd1,
    SLOT_HELD = 2'd2
  } slot_state_e;
endpackage

// File: rtl/iq_alloc.sv
module iq_alloc #(
  parameter int DEPTH   = 20,
  parameter int DISP_W  = 2,
  parameter int DLANE_W = 1
) (
  input  logic [DEPTH-1:0]         free_i,
  input  logic [DISP_W-1:0]        disp_valid_i,
  input  logic                     squash_i,
  output logic [DEPTH-1:0]         alloc_o,
  output logic [DEPTH*DLANE_W-1:0] lane_o,
  output logic                     full_o
);
  int n_free;
  int rank;

  always_comb begin
    n_free = 0;
    for (int i = 0; i < DEPTH; i++) begin
      if (free_i[i]) n_free++;
    end
    full_o = (n_free < DISP_W);
  end

  // lane k lands in the k-th lowest free slot
  always_comb begin
    rank    = 0;
    alloc_o = '0;
    lane_o  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (free_i[i]) begin
        if (rank < DISP_W) begin
          if (!full_o && !squash_i && disp_valid_i[rank]) begin
            alloc_o[i] = 1'b1;
            lane_o[i*DLANE_W +: DLANE_W] = DLANE_W'(rank);
          end
        end
        rank++;
      end
    end
  end
endmodule

// File: rtl/iq_select.sv
module iq_select #(
  parameter int DEPTH   = 20,
  parameter int ISSUE_W = 4,
  parameter int ILANE_W = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [DEPTH-1:0]         alloc_i,
  input  logic [DEPTH-1:0]         valid_i,
  input  logic [DEPTH-1:0]         ready_i,
  output logic [DEPTH-1:0]         grant_o,
  output logic [DEPTH*ILANE_W-1:0] lane_o
);
  // older_q[i][j]: slot j holds an older instruction than slot i
  logic [DEPTH-1:0] older_q [DEPTH];
  int n_older;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) older_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        for (int j = 0; j < DEPTH; j++) begin
          if (alloc_i[i]) begin
            older_q[i][j] <= (valid_i[j] && !alloc_i[j]) || (alloc_i[j] && (j < i));
          end else if (alloc_i[j]) begin
            older_q[i][j] <= 1'b0;
          end
        end
      end
    end
  end

  // rank among ready entries = number of older ready entries
  always_comb begin
    grant_o = '0;
    lane_o  = '0;
    n_older = 0;
    for (int i = 0; i < DEPTH; i++) begin
      n_older = 0;
      for (int j = 0; j < DEPTH; j++) begin
        if (older_q[i][j] && ready_i[j]) n_older++;
      end
      if (ready_i[i] && (n_older < ISSUE_W)) begin
        grant_o[i] = 1'b1;
        lane_o[i*ILANE_W +: ILANE_W] = ILANE_W'(n_older);
      end
    end
  end
endmodule

// File: rtl/iq_slot.sv
module iq_slot
  import iq_pkg::*;
#(
  parameter int NSRC       = 2,
  parameter int TAG_W      = 6,
  parameter int PAY_W      = 12,
  parameter int WAKE_W     = 2,
  parameter int REPLAY_WIN = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    alloc_i,
  input  logic [NSRC*TAG_W-1:0]   alloc_tag_i,
  input  logic [NSRC-1:0]         alloc_rdy_i,
  input  logic [PAY_W-1:0]        alloc_pay_i,
  input  logic [WAKE_W-1:0]       wake_valid_i,
  input  logic [WAKE_W*TAG_W-1:0] wake_tag_i,
  input  logic                    grant_i,
  input  logic                    squash_i,
  input  logic                    replay_i,
  input  logic [TAG_W-1:0]        replay_tag_i,
  output logic                    valid_o,
  output logic                    ready_o,
  output logic                    held_o,
  output logic [PAY_W-1:0]        payload_o
);
  localparam int CNT_W = (REPLAY_WIN > 1) ? $clog2(REPLAY_WIN) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(REPLAY_WIN - 1);

  slot_state_e              st_q;
  logic [CNT_W-1:0]         cnt_q;
  logic [NSRC*TAG_W-1:0]    tag_q;
  logic [NSRC-1:0]          rdy_q;
  logic [PAY_W-1:0]         pay_q;
  logic [NSRC-1:0]          wm_cur, wm_new, rm;

  always_comb begin
    wm_cur = '0;
    wm_new = '0;
    rm     = '0;
    for (int s = 0; s < NSRC; s++) begin
      for (int w = 0; w < WAKE_W; w++) begin
        if (wake_valid_i[w]) begin
          if (wake_tag_i[w*TAG_W +: TAG_W] == tag_q[s*TAG_W +: TAG_W]) wm_cur[s] = 1'b1;
          if (wake_tag_i[w*TAG_W +: TAG_W] == alloc_tag_i[s*TAG_W +: TAG_W]) wm_new[s] = 1'b1;
        end
      end
      rm[s] = (replay_tag_i == tag_q[s*TAG_W +: TAG_W]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SLOT_FREE;
      cnt_q <= '0;
      tag_q <= '0;
      rdy_q <= '0;
      pay_q <= '0;
    end else if (squash_i) begin
      st_q <= SLOT_FREE;
    end else begin
      unique case (st_q)
        SLOT_FREE: begin
          if (alloc_i) begin
            st_q  <= SLOT_WAIT;
            tag_q <= alloc_tag_i;
            rdy_q <= alloc_rdy_i | wm_new;
            pay_q <= alloc_pay_i;
          end
        end
        SLOT_WAIT: begin
          rdy_q <= rdy_q | wm_cur;
          if (grant_i) begin
            st_q  <= SLOT_HELD;
            cnt_q <= '0;
          end
        end
        SLOT_HELD: begin
          if (replay_i) begin
            st_q  <= SLOT_WAIT;
            rdy_q <= (rdy_q & ~rm) | wm_cur;
          end else if (cnt_q == LAST) begin
            st_q <= SLOT_FREE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= SLOT_FREE;
      endcase
    end
  end

  assign valid_o   = (st_q != SLOT_FREE);
  assign ready_o   = (st_q == SLOT_WAIT) && (&rdy_q);
  assign held_o    = (st_q == SLOT_HELD);
  assign payload_o = pay_q;
endmodule

// File: rtl/age_issue_queue.sv
module age_issue_queue #(
  parameter int DEPTH      = 20,
  parameter int ISSUE_W    = 4,
  parameter int DISP_W     = 2,
  parameter int WAKE_W     = 2,
  parameter int NSRC       = 2,
  parameter int TAG_W      = 6,
  parameter int PAY_W      = 12,
  parameter int REPLAY_WIN = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [DISP_W-1:0]             disp_valid_i,
  input  logic [DISP_W*NSRC*TAG_W-1:0]  disp_src_tag_i,
  input  logic [DISP_W*NSRC-1:0]        disp_src_rdy_i,
  input  logic [DISP_W*PAY_W-1:0]       disp_payload_i,
  output logic                          full_o,
  input  logic [WAKE_W-1:0]             wake_valid_i,
  input  logic [WAKE_W*TAG_W-1:0]       wake_tag_i,
  output logic [ISSUE_W-1:0]            issue_valid_o,
  output logic [ISSUE_W*PAY_W-1:0]      issue_payload_o,
  input  logic                          squash_i,
  input  logic                          replay_i,
  input  logic [TAG_W-1:0]              replay_tag_i
);
  localparam int DLANE_W  = (DISP_W > 1) ? $clog2(DISP_W) : 1;
  localparam int ILANE_W  = (ISSUE_W > 1) ? $clog2(ISSUE_W) : 1;
  localparam int SRC_BITS = NSRC * TAG_W;

  logic [DEPTH-1:0]         slot_valid, slot_ready, slot_held, slot_alloc, slot_grant, slot_free;
  logic [DEPTH*DLANE_W-1:0] alloc_lane;
  logic [DEPTH*ILANE_W-1:0] grant_lane;
  logic [PAY_W-1:0]         slot_pay [DEPTH];

  assign slot_free = ~slot_valid;

  iq_alloc #(.DEPTH(DEPTH), .DISP_W(DISP_W), .DLANE_W(DLANE_W)) u_alloc (
    .free_i      (slot_free),
    .disp_valid_i(disp_valid_i),
    .squash_i    (squash_i),
    .alloc_o     (slot_alloc),
    .lane_o      (alloc_lane),
    .full_o      (full_o)
  );

  iq_select #(.DEPTH(DEPTH), .ISSUE_W(ISSUE_W), .ILANE_W(ILANE_W)) u_select (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .alloc_i(slot_alloc),
    .valid_i(slot_valid),
    .ready_i(slot_ready),
    .grant_o(slot_grant),
    .lane_o (grant_lane)
  );

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [DLANE_W-1:0]  ln;
    logic [SRC_BITS-1:0] tag_sel;
    logic [NSRC-1:0]     rdy_sel;
    logic [PAY_W-1:0]    pay_sel;

    assign ln = alloc_lane[g*DLANE_W +: DLANE_W];

    always_comb begin
      tag_sel = disp_src_tag_i[int'(ln)*SRC_BITS +: SRC_BITS];
      rdy_sel = disp_src_rdy_i[int'(ln)*NSRC +: NSRC];
      pay_sel = disp_payload_i[int'(ln)*PAY_W +: PAY_W];
    end

    iq_slot #(
      .NSRC(NSRC), .TAG_W(TAG_W), .PAY_W(PAY_W),
      .WAKE_W(WAKE_W), .REPLAY_WIN(REPLAY_WIN)
    ) u_slot (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .alloc_i     (slot_alloc[g]),
      .alloc_tag_i (tag_sel),
      .alloc_rdy_i (rdy_sel),
      .alloc_pay_i (pay_sel),
      .wake_valid_i(wake_valid_i),
      .wake_tag_i  (wake_tag_i),
      .grant_i     (slot_grant[g]),
      .squash_i    (squash_i),
      .replay_i    (replay_i),
      .replay_tag_i(replay_tag_i),
      .valid_o     (slot_valid[g]),
      .ready_o     (slot_ready[g]),
      .held_o      (slot_held[g]),
      .payload_o   (slot_pay[g])
    );
  end

  always_comb begin
    issue_valid_o   = '0;
    issue_payload_o = '0;
    for (int l = 0; l < ISSUE_W; l++) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (slot_grant[i] && (grant_lane[i*ILANE_W +: ILANE_W] == ILANE_W'(l))) begin
          issue_valid_o[l] = 1'b1;
          issue_payload_o[l*PAY_W +: PAY_W] = issue_payload_o[l*PAY_W +: PAY_W] | slot_pay[i];
        end
      end
    end
  end
endmodule

// File: rtl/iq_checker.sv
module iq_checker #(
  parameter int DEPTH   = 20,
  parameter int ISSUE_W = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               squash_i,
  input logic               replay_i,
  input logic               full_i,
  input logic [ISSUE_W-1:0] issue_valid_i,
  input logic [DEPTH-1:0]   valid_i,
  input logic [DEPTH-1:0]   ready_i,
  input logic [DEPTH-1:0]   held_i,
  input logic [DEPTH-1:0]   alloc_i
);
  int n_ready;
  int n_expect;

  always_comb begin
    n_ready = 0;
    for (int i = 0; i < DEPTH; i++) if (ready_i[i]) n_ready++;
    n_expect = (n_ready > ISSUE_W) ? ISSUE_W : n_ready;
  end

  a_r4_issue_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(issue_valid_i) == n_expect);

  for (genvar l = 1; l < ISSUE_W; l++) begin : g_pack
    a_r4_lanes_packed: assert property (@(posedge clk_i) disable iff (!rst_ni)
      issue_valid_i[l] |-> issue_valid_i[l-1]);
  end

  a_r8_full_blocks_alloc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_i |-> (alloc_i == '0));

  a_r9_squash_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_i |=> (valid_i == '0));

  a_r6_replay_returns_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    replay_i |=> ((held_i & $past(held_i)) == '0));
endmodule

bind age_issue_queue iq_checker #(.DEPTH(DEPTH), .ISSUE_W(ISSUE_W)) u_iq_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .squash_i     (squash_i),
  .replay_i     (replay_i),
  .full_i       (full_o),
  .issue_valid_i(issue_valid_o),
  .valid_i      (slot_valid),
  .ready_i      (slot_ready),
  .held_i       (slot_held),
  .alloc_i      (slot_alloc)
);

// File: tb/age_issue_queue_tb_top.sv
module age_issue_queue_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 20, ISSUE_W = 4, DISP_W = 2, WAKE_W = 2;
  localparam int NSRC = 2, TAG_W = 6, PAY_W = 12, REPLAY_WIN = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DISP_W-1:0]            disp_valid;
  logic [DISP_W*NSRC*TAG_W-1:0] disp_tag;
  logic [DISP_W*NSRC-1:0]       disp_rdy;
  logic [DISP_W*PAY_W-1:0]      disp_pay;
  logic                         full;
  logic [WAKE_W-1:0]            wake_valid;
  logic [WAKE_W*TAG_W-1:0]      wake_tag;
  logic [ISSUE_W-1:0]           issue_valid;
  logic [ISSUE_W*PAY_W-1:0]     issue_pay;
  logic                         squash, replay;
  logic [TAG_W-1:0]             replay_tag;

  int cyc = 0;
  int checks = 0;
  int errors = 0;

  typedef struct {
    int    cyc;
    int    lane;
    int    pay;
    string req;
  } exp_t;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  age_issue_queue #(
    .DEPTH(DEPTH), .ISSUE_W(ISSUE_W), .DISP_W(DISP_W), .WAKE_W(WAKE_W),
    .NSRC(NSRC), .TAG_W(TAG_W), .PAY_W(PAY_W), .REPLAY_WIN(REPLAY_WIN)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .disp_valid_i(disp_valid), .disp_src_tag_i(disp_tag),
    .disp_src_rdy_i(disp_rdy), .disp_payload_i(disp_pay),
    .full_o(full),
    .wake_valid_i(wake_valid), .wake_tag_i(wake_tag),
    .issue_valid_o(issue_valid), .issue_payload_o(issue_pay),
    .squash_i(squash), .replay_i(replay), .replay_tag_i(replay_tag)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic expect_at(int c, int lane, int pay, string req);
    exp_t e;
    e.cyc = c; e.lane = lane; e.pay = pay; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic clear_in();
    disp_valid = '0; disp_tag = '0; disp_rdy = '0; disp_pay = '0;
    wake_valid = '0; wake_tag = '0;
    squash = 1'b0; replay = 1'b0; replay_tag = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    clear_in();
  endtask

  task automatic put_disp(int lane, int pay, int t0, bit r0, int t1, bit r1);
    disp_valid[lane] = 1'b1;
    disp_pay[lane*PAY_W +: PAY_W] = PAY_W'(pay);
    disp_tag[(lane*NSRC)*TAG_W +: TAG_W] = TAG_W'(t0);
    disp_tag[(lane*NSRC+1)*TAG_W +: TAG_W] = TAG_W'(t1);
    disp_rdy[lane*NSRC] = r0;
    disp_rdy[lane*NSRC+1] = r1;
  endtask

  task automatic put_wake(int lane, int tag);
    wake_valid[lane] = 1'b1;
    wake_tag[lane*TAG_W +: TAG_W] = TAG_W'(tag);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    int n_exp;
    exp_t e;
    if (rst_n) begin
      n_exp = 0;
      while (exp_q.size() > 0 && exp_q[0].cyc < cyc) begin
        e = exp_q.pop_front();
        checks++; errors++;
        $display("FAIL %s lane %0d actual none expected %h at cycle %0d", e.req, e.lane, e.pay, e.cyc);
      end
      while (exp_q.size() > 0 && exp_q[0].cyc == cyc) begin
        e = exp_q.pop_front();
        checks++;
        n_exp++;
        if (!issue_valid[e.lane] || issue_pay[e.lane*PAY_W +: PAY_W] != PAY_W'(e.pay)) begin
          errors++;
          $display("FAIL %s lane %0d actual v=%0b %h expected %h at cycle %0d", e.req, e.lane,
                   issue_valid[e.lane], issue_pay[e.lane*PAY_W +: PAY_W], e.pay, cyc);
        end
      end
      checks++;
      if ($countones(issue_valid) != n_exp) begin
        errors++;
        $display("FAIL R2 R4 R7 R8 R9 issue count actual %0d expected %0d at cycle %0d",
                 $countones(issue_valid), n_exp, cyc);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int a, b, d, w;
    clear_in();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    chk("R1 full", int'(full), 0);
    chk("R1 issue", int'(issue_valid), 0);
    tick();

    // R2 ready at dispatch, R4 lane order within a dispatch cycle
    put_disp(0, 'h101, 1, 1, 2, 1);
    put_disp(1, 'h102, 3, 1, 4, 1);
    expect_at(cyc + 1, 0, 'h101, "R2");
    expect_at(cyc + 1, 1, 'h102, "R4");
    repeat (5) tick();

    // R2 both sources woken on different cycles and lanes
    put_disp(0, 'h201, 7, 0, 8, 0);
    tick();
    put_wake(0, 7);
    tick();
    tick();
    put_wake(1, 8);
    expect_at(cyc + 1, 0, 'h201, "R2");
    repeat (5) tick();

    // R3 wakeup in dispatch cycle
    put_disp(0, 'h202, 33, 0, 1, 1);
    put_wake(0, 33);
    expect_at(cyc + 1, 0, 'h202, "R3");
    repeat (5) tick();

    // R4 age differs from slot order
    a = cyc;
    put_disp(0, 'h301, 9, 0, 1, 1);
    put_disp(1, 'h302, 40, 0, 1, 1);
    tick();
    put_disp(0, 'h303, 40, 0, 1, 1);
    put_disp(1, 'h304, 9, 0, 1, 1);
    tick();
    put_wake(0, 40);
    expect_at(a + 3, 0, 'h302, "R4");
    expect_at(a + 3, 1, 'h303, "R4");
    repeat (4) tick();
    put_disp(0, 'h305, 9, 0, 1, 1);
    put_disp(1, 'h306, 9, 0, 1, 1);
    tick();
    put_disp(0, 'h307, 1, 1, 9, 0);
    put_disp(1, 'h308, 9, 0, 1, 1);
    tick();
    put_wake(1, 9);
    expect_at(a + 9, 0, 'h301, "R4");
    expect_at(a + 9, 1, 'h304, "R4");
    expect_at(a + 9, 2, 'h305, "R4");
    expect_at(a + 9, 3, 'h306, "R4");
    expect_at(a + 10, 0, 'h307, "R4");
    expect_at(a + 10, 1, 'h308, "R4");
    repeat (6) tick();

    // R6 replay with matching tag, in both window cycles; R7 after window
    b = cyc;
    put_disp(0, 'h401, 12, 0, 1, 1);
    put_disp(1, 'h402, 1, 1, 12, 0);
    tick();
    put_wake(0, 12);
    expect_at(b + 2, 0, 'h401, "R6");
    expect_at(b + 2, 1, 'h402, "R6");
    tick();
    tick();
    replay = 1'b1; replay_tag = 6'd12;
    tick();
    tick();
    put_wake(1, 12);
    expect_at(b + 6, 0, 'h401, "R6");
    expect_at(b + 6, 1, 'h402, "R6");
    tick();
    tick();
    tick();
    replay = 1'b1; replay_tag = 6'd12;
    tick();
    put_wake(0, 12);
    expect_at(b + 10, 0, 'h401, "R6");
    expect_at(b + 10, 1, 'h402, "R6");
    repeat (4) tick();
    replay = 1'b1; replay_tag = 6'd12;
    tick();
    put_wake(0, 12);
    tick();
    repeat (3) tick();
    chk("R7 queue empty", int'(full), 0);

    // R6 replay with non-matching tag reissues next cycle
    d = cyc;
    put_disp(0, 'h403, 1, 1, 2, 1);
    expect_at(d + 1, 0, 'h403, "R6");
    tick();
    tick();
    replay = 1'b1; replay_tag = 6'd14;
    expect_at(d + 3, 0, 'h403, "R6");
    tick();
    repeat (5) tick();

    // R8 full, R5 release timing
    for (int k = 0; k < DEPTH / DISP_W; k++) begin
      if (k == DEPTH / DISP_W - 1) chk("R8 not full with two free", int'(full), 0);
      put_disp(0, 'h500 + 2*k, 50, 0, 1, 1);
      put_disp(1, 'h501 + 2*k, 1, 1, 50, 0);
      tick();
    end
    chk("R8 full", int'(full), 1);
    put_disp(0, 'hEEE, 50, 0, 1, 1);
    put_disp(1, 'hEEF, 50, 0, 1, 1);
    tick();
    chk("R8 still full", int'(full), 1);
    w = cyc;
    put_wake(0, 50);
    for (int g = 0; g < DEPTH / ISSUE_W; g++)
      for (int l = 0; l < ISSUE_W; l++)
        expect_at(w + 1 + g, l, 'h500 + g*ISSUE_W + l, "R4");
    tick();
    tick();
    tick();
    chk("R5 held in last window cycle", int'(full), 1);
    tick();
    chk("R5 released after window", int'(full), 0);
    repeat (8) tick();

    // R9 squash
    put_disp(0, 'h601, 60, 0, 1, 1);
    put_disp(1, 'h602, 60, 0, 1, 1);
    tick();
    squash = 1'b1;
    put_disp(0, 'h603, 1, 1, 2, 1);
    tick();
    put_wake(0, 60);
    tick();
    repeat (3) tick();
    chk("R9 empty after squash", int'(full), 0);
    put_disp(0, 'h604, 1, 1, 2, 1);
    expect_at(cyc + 1, 0, 'h604, "R9");
    repeat (5) tick();
    put_disp(0, 'h605, 1, 1, 2, 1);
    expect_at(cyc + 1, 0, 'h605, "R9");
    tick();
    tick();
    squash = 1'b1;
    tick();
    replay = 1'b1; replay_tag = 6'd0;
    tick();
    repeat (4) tick();

    chk("R2 all expected issues seen", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule